// File: doc/BRIEF.md
# Programmable priority interrupt controller

This block collects interrupt requests from a set of peripheral and external sources and presents one of them at a time to a CPU. A rising edge on a source input sets a sticky request flag, and only software can clear that flag. Each source also has an enable bit and a 3-bit priority. Among the flagged, enabled sources with a non-zero priority, the highest priority wins. On a tie, the lowest source index wins. The winner is compared with the CPU's 4-bit current level. The top bit of that level is a trap indication that software cannot change.

When the winner's priority is strictly above the CPU level, the block raises `irq_req` and presents a vector number (source index plus a base of 8) and the new level. The CPU takes the request with `irq_ack` and ends each handler with `irq_ret`. A status word holds the vector and level of the top pending request. It tracks that request every cycle outside service and holds while an interrupt is being serviced. A control bit turns nesting off. With nesting off, no user interrupt can be raised while a handler runs.

The sequencer has three states:
- IDLE: no request is raised.
- REQ: a request is raised and waits for acknowledge.
- SERVE: one or more handlers are active.

Its transitions are:
- IDLE to REQ: a winner beats the threshold.
- REQ to SERVE: acknowledge arrives while the request is raised.
- REQ to IDLE: the winner goes away before acknowledge.
- SERVE to IDLE or REQ: the return that brings the nesting depth to zero. The next state is REQ if a winner beats the threshold at that moment, and IDLE otherwise.
- SERVE to SERVE: a nested acknowledge or a non-final return.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every flag, enable, priority and the nesting-off bit read as 0, the status word reads 0 and `irq_req` is low.
- R2: A rising edge on `src_in[i]` sets flag i (address 1, bit i). The flag stays set after the input falls. Writing 1 to bit i at address 1 clears it, and writing 0 leaves it unchanged.
- R3: When a rising edge and a clearing write to the same flag fall in one cycle, the flag ends up set.
- R4: A source with its enable bit (address 2, bit i) clear, or with priority 0, never raises `irq_req`, although its flag still reads back as set.
- R5: The highest priority wins. Equal priorities go to the lower index. `irq_vec` equals the source index plus 8, and `irq_lvl` equals the winner's priority with bit 3 clear.
- R6: A request is raised only when the winner's priority is strictly greater than the CPU level {`cpu_trap`, `cpu_ipl`}. While `cpu_trap` is 1, no request is raised.
- R7: `irq_req`, `irq_vec` and `irq_lvl` are registered. They reflect the flags, enables, priorities and CPU level of the previous cycle.
- R8: `irq_ack` while `irq_req` is high enters SERVE and drops `irq_req` in the next cycle. `irq_ack` while `irq_req` is low has no effect.
- R9: The status word (address 15: vector in bits 6:0, level in bits 11:8) takes the top pending enabled request every cycle outside SERVE. It holds from the accepted acknowledge until the final return.
- R10: With the nesting-off bit (address 0, bit 0) set, no request is raised during SERVE, whatever the CPU level.
- R11: With nesting allowed, a request above the CPU level is raised during SERVE. Each accepted acknowledge adds one to the depth, each return removes one, and SERVE is left when the depth reaches zero.
- R12: Priorities are written and read at address 3 + i/4, in bits 4*(i%4)+2 down to 4*(i%4). Bit 3 of each nibble is not stored and reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| src_in | input | NUM_SRC | Source request inputs, edge sensitive |
| cpu_ipl | input | 3 | Software-settable part of the CPU level |
| cpu_trap | input | 1 | Trap bit of the CPU level |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 7 | Vector number of the winning source |
| irq_lvl | output | 4 | New level of the winning source |
| irq_ack | input | 1 | CPU accepts the raised request |
| irq_ret | input | 1 | CPU returns from a handler |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a source edge and a software clear of the same flag. The bench raises `src_in` in the very cycle that it writes 1 to that flag bit. It then reads address 1, expecting the flag to be set.

The second pair is an accepted acknowledge and the status update. The bench pulses a higher-priority source while a handler is being serviced and reads address 15 in those cycles. It expects the status word to keep the acknowledged vector until the final return, and to take the new winner right after.

A behavioural model in the bench predicts the request, vector, level and read data for every cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_SERVE = 2'd2
    } irq_state_e;

    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_FLAG    = 1;
    localparam int ADDR_EN      = 2;
    localparam int ADDR_PRI0    = 3;
    localparam int ADDR_STAT    = 15;

    localparam int PRI_W        = 3;
    localparam int LVL_W        = 4;
    localparam int VEC_W        = 7;
    localparam int SRC_PER_WORD = 4;
    localparam int NIB_W        = 4;

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_SRC-1:0]         src_in,
    input  logic [DATA_W-1:0]          stat_word,
    output logic [NUM_SRC-1:0]         flags,
    output logic [NUM_SRC-1:0]         enables,
    output logic [NUM_SRC*PRI_W-1:0]   pri_flat,
    output logic                       nest_off
);

    logic wr_ctrl, wr_flag, wr_en;
    logic [NUM_SRC-1:0] en_q;
    logic               nest_q;

    assign wr_ctrl = bus_we && (int'(bus_addr) == ADDR_CTRL);
    assign wr_flag = bus_we && (int'(bus_addr) == ADDR_FLAG);
    assign wr_en   = bus_we && (int'(bus_addr) == ADDR_EN);

    // Per-source flag with edge detect, and priority field
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam int WORD = ADDR_PRI0 + s / SRC_PER_WORD;
        localparam int NIB  = (s % SRC_PER_WORD) * NIB_W;

        logic             flag_q;
        logic             prev_q;
        logic             rise;
        logic [PRI_W-1:0] pri_q;

        assign rise = src_in[s] & ~prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                prev_q <= src_in[s];
                // a new edge outranks a clear in the same cycle
                if (rise)
                    flag_q <= 1'b1;
                else if (wr_flag && bus_wdata[s])
                    flag_q <= 1'b0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pri_q <= '0;
            else if (bus_we && (int'(bus_addr) == WORD))
                pri_q <= bus_wdata[NIB +: PRI_W];
        end

        assign flags[s]                   = flag_q;
        assign pri_flat[s*PRI_W +: PRI_W] = pri_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            nest_q <= 1'b0;
        end else begin
            if (wr_en)
                en_q <= bus_wdata[NUM_SRC-1:0];
            if (wr_ctrl)
                nest_q <= bus_wdata[0];
        end
    end

    assign enables  = en_q;
    assign nest_off = nest_q;

    always_comb begin
        bus_rdata = '0;
        if (int'(bus_addr) == ADDR_CTRL) begin
            bus_rdata[0] = nest_q;
        end else if (int'(bus_addr) == ADDR_FLAG) begin
            bus_rdata[NUM_SRC-1:0] = flags;
        end else if (int'(bus_addr) == ADDR_EN) begin
            bus_rdata[NUM_SRC-1:0] = en_q;
        end else if (int'(bus_addr) == ADDR_STAT) begin
            bus_rdata = stat_word;
        end else begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (int'(bus_addr) == ADDR_PRI0 + s / SRC_PER_WORD)
                    bus_rdata[(s % SRC_PER_WORD)*NIB_W +: PRI_W] =
                        pri_flat[s*PRI_W +: PRI_W];
            end
        end
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int IDX_W   = 3
) (
    input  logic [NUM_SRC-1:0]       flags,
    input  logic [NUM_SRC-1:0]       enables,
    input  logic [NUM_SRC*PRI_W-1:0] pri_flat,
    output logic                     best_valid,
    output logic [IDX_W-1:0]         best_idx,
    output logic [PRI_W-1:0]         best_pri
);

    // Ascending scan with strict compare: lowest index keeps a tie,
    // and a priority of 0 can never replace the empty start value.
    always_comb begin
        best_pri = '0;
        best_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (flags[i] && enables[i] &&
                (pri_flat[i*PRI_W +: PRI_W] > best_pri)) begin
                best_pri = pri_flat[i*PRI_W +: PRI_W];
                best_idx = IDX_W'(i);
            end
        end
        best_valid = (best_pri != '0);
    end

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import irq_pkg::*;
#(
    parameter int IDX_W    = 3,
    parameter int VEC_BASE = 8,
    parameter int DEPTH_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             best_valid,
    input  logic [IDX_W-1:0] best_idx,
    input  logic [PRI_W-1:0] best_pri,
    input  logic [LVL_W-1:0] cpu_lvl,
    input  logic             nest_off,
    input  logic             irq_ack,
    input  logic             irq_ret,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [LVL_W-1:0] irq_lvl,
    output logic [VEC_W-1:0] stat_vec,
    output logic [LVL_W-1:0] stat_lvl,
    output logic             serving
);

    localparam logic [LVL_W-1:0] USER_TOP = LVL_W'((1 << PRI_W) - 1);

    irq_state_e         state_q, state_d;
    logic [DEPTH_W-1:0] depth_q, depth_d;
    logic [LVL_W-1:0]   thresh;
    logic               win, accept, ret_ok, req_d;
    logic [VEC_W-1:0]   cand_vec;
    logic [LVL_W-1:0]   cand_lvl;
    logic               req_q;
    logic [VEC_W-1:0]   vec_q, svec_q;
    logic [LVL_W-1:0]   lvl_q, slvl_q;

    // With nesting off, servicing lifts the threshold above every user level
    always_comb begin
        if (state_q == ST_SERVE && nest_off)
            thresh = (cpu_lvl > USER_TOP) ? cpu_lvl : USER_TOP;
        else
            thresh = cpu_lvl;
    end

    assign win      = best_valid && ({1'b0, best_pri} > thresh);
    assign accept   = irq_ack && req_q;
    assign ret_ok   = irq_ret && (state_q == ST_SERVE);
    assign req_d    = win && !accept;
    assign depth_d  = depth_q + DEPTH_W'(accept) - DEPTH_W'(ret_ok);
    assign cand_vec = best_valid ? (VEC_W'(VEC_BASE) + VEC_W'(best_idx)) : '0;
    assign cand_lvl = best_valid ? {1'b0, best_pri} : '0;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = req_d ? ST_REQ : ST_IDLE;
            ST_REQ:   state_d = accept ? ST_SERVE : (req_d ? ST_REQ : ST_IDLE);
            ST_SERVE: begin
                if (depth_d == '0)
                    state_d = req_d ? ST_REQ : ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            depth_q <= '0;
        end else begin
            state_q <= state_d;
            depth_q <= depth_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            vec_q  <= '0;
            lvl_q  <= '0;
            svec_q <= '0;
            slvl_q <= '0;
        end else begin
            req_q <= req_d;
            vec_q <= cand_vec;
            lvl_q <= cand_lvl;
            if (state_q != ST_SERVE && !accept) begin
                svec_q <= cand_vec;
                slvl_q <= cand_lvl;
            end
        end
    end

    assign irq_req  = req_q;
    assign irq_vec  = vec_q;
    assign irq_lvl  = lvl_q;
    assign stat_vec = svec_q;
    assign stat_lvl = slvl_q;
    assign serving  = (state_q == ST_SERVE);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 4,
    parameter int VEC_BASE = 8,
    parameter int DEPTH_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [2:0]         cpu_ipl,
    input  logic               cpu_trap,
    output logic               irq_req,
    output logic [6:0]         irq_vec,
    output logic [3:0]         irq_lvl,
    input  logic               irq_ack,
    input  logic               irq_ret
);

    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int STAT_W = LVL_W + 1 + VEC_W;

    logic [NUM_SRC-1:0]       flags, enables;
    logic [NUM_SRC*PRI_W-1:0] pri_flat;
    logic                     nest_off, best_valid, serving;
    logic [IDX_W-1:0]         best_idx;
    logic [PRI_W-1:0]         best_pri;
    logic [VEC_W-1:0]         stat_vec;
    logic [LVL_W-1:0]         stat_lvl;
    logic [DATA_W-1:0]        stat_word;
    logic [LVL_W-1:0]         cpu_lvl;

    assign cpu_lvl   = {cpu_trap, cpu_ipl};
    assign stat_word = {{(DATA_W-STAT_W){1'b0}}, stat_lvl, 1'b0, stat_vec};

    irq_regfile #(
        .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .stat_word(stat_word), .flags(flags), .enables(enables),
        .pri_flat(pri_flat), .nest_off(nest_off)
    );

    irq_arbiter #(
        .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
    ) u_arb (
        .flags(flags), .enables(enables), .pri_flat(pri_flat),
        .best_valid(best_valid), .best_idx(best_idx), .best_pri(best_pri)
    );

    irq_sequencer #(
        .IDX_W(IDX_W), .VEC_BASE(VEC_BASE), .DEPTH_W(DEPTH_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .best_valid(best_valid),
        .best_idx(best_idx), .best_pri(best_pri), .cpu_lvl(cpu_lvl),
        .nest_off(nest_off), .irq_ack(irq_ack), .irq_ret(irq_ret),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .stat_vec(stat_vec), .stat_lvl(stat_lvl), .serving(serving)
    );

endmodule

module irq_prio_chk #(
    parameter int VEC_BASE = 8,
    parameter int DATA_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              irq_ack,
    input logic              cpu_trap,
    input logic              serving,
    input logic              nest_off,
    input logic [6:0]        irq_vec,
    input logic [3:0]        irq_lvl,
    input logic [DATA_W-1:0] stat_word
);

    p_ack_drops_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !irq_req);

    p_trap_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_trap |=> !irq_req);

    p_user_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec >= 7'(VEC_BASE) && irq_lvl != 4'd0 && !irq_lvl[3]));

    p_status_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (serving || (irq_ack && irq_req)) |=> $stable(stat_word));

    p_nest_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (serving && nest_off) |=> !irq_req);

endmodule

bind irq_prio_ctrl irq_prio_chk #(.VEC_BASE(VEC_BASE), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .cpu_trap(cpu_trap), .serving(serving), .nest_off(nest_off),
    .irq_vec(irq_vec), .irq_lvl(irq_lvl), .stat_word(stat_word)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [NS-1:0] src_in = '0;
    logic [2:0]  cpu_ipl = '0;
    logic        cpu_trap = 1'b0;
    logic        irq_req;
    logic [6:0]  irq_vec;
    logic [3:0]  irq_lvl;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    int m_flag[NS];
    int m_en[NS];
    int m_pri[NS];
    int m_prev[NS];
    int m_nest = 0, m_state = 0, m_depth = 0;
    int m_req = 0, m_vec = 0, m_lvl = 0, m_svec = 0, m_slvl = 0;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
        .cpu_ipl(cpu_ipl), .cpu_trap(cpu_trap), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_lvl(irq_lvl), .irq_ack(irq_ack),
        .irq_ret(irq_ret)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_flag[i] = 0; m_en[i] = 0; m_pri[i] = 0; m_prev[i] = 0;
            end
            m_nest = 0; m_state = 0; m_depth = 0;
            m_req = 0; m_vec = 0; m_lvl = 0; m_svec = 0; m_slvl = 0;
        end else begin
            int bp, bi, cpu, thr, win, acc, rt, nd, nreq, ns;
            bp = 0; bi = 0;
            for (int i = 0; i < NS; i++)
                if (m_flag[i] != 0 && m_en[i] != 0 && m_pri[i] > bp) begin
                    bp = m_pri[i]; bi = i;
                end
            cpu  = (cpu_trap ? 8 : 0) + int'(cpu_ipl);
            thr  = (m_state == 2 && m_nest != 0) ? ((cpu > 7) ? cpu : 7) : cpu;
            win  = (bp > thr) ? 1 : 0;
            acc  = (irq_ack && m_req != 0) ? 1 : 0;
            rt   = (irq_ret && m_state == 2) ? 1 : 0;
            nd   = m_depth + acc - rt;
            nreq = (win != 0 && acc == 0) ? 1 : 0;
            if (m_state == 0)      ns = nreq != 0 ? 1 : 0;
            else if (m_state == 1) ns = acc != 0 ? 2 : (nreq != 0 ? 1 : 0);
            else                   ns = nd == 0 ? (nreq != 0 ? 1 : 0) : 2;
            if (m_state != 2 && acc == 0) begin
                m_svec = bp > 0 ? bi + 8 : 0;
                m_slvl = bp;
            end
            m_vec = bp > 0 ? bi + 8 : 0;
            m_lvl = bp;
            m_req = nreq; m_state = ns; m_depth = nd;
            for (int i = 0; i < NS; i++) begin
                if (src_in[i] && m_prev[i] == 0) m_flag[i] = 1;
                else if (bus_we && bus_addr == 1 && bus_wdata[i]) m_flag[i] = 0;
                m_prev[i] = src_in[i] ? 1 : 0;
            end
            if (bus_we) begin
                if (bus_addr == 0) m_nest = bus_wdata[0] ? 1 : 0;
                if (bus_addr == 2)
                    for (int i = 0; i < NS; i++) m_en[i] = bus_wdata[i] ? 1 : 0;
                if (bus_addr == 3 || bus_addr == 4)
                    for (int j = 0; j < 4; j++)
                        m_pri[(int'(bus_addr) - 3) * 4 + j] = (int'(bus_wdata) >> (4 * j)) & 7;
            end
        end
    end

    function automatic int model_rd(int a);
        int v = 0;
        if (a == 0) v = m_nest;
        else if (a == 1) begin for (int i = 0; i < NS; i++) v += m_flag[i] << i; end
        else if (a == 2) begin for (int i = 0; i < NS; i++) v += m_en[i] << i; end
        else if (a == 3 || a == 4) begin
            for (int j = 0; j < 4; j++) v += m_pri[(a - 3) * 4 + j] << (4 * j);
        end
        else if (a == 15) v = (m_slvl << 8) | m_svec;
        return v;
    endfunction

    task automatic chk(string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
        chk("irq_req", int'(irq_req), m_req);
        chk("irq_vec", int'(irq_vec), m_vec);
        chk("irq_lvl", int'(irq_lvl), m_lvl);
        chk("bus_rdata", int'(bus_rdata), model_rd(int'(bus_addr)));
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(int a, int d);
        bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(int a);
        bus_addr = 4'(a);
        step();
    endtask

    task automatic pulse(int mask);
        src_in = NS'(mask);
        step();
        src_in = '0;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset values
        cyc(3);
        rst_n = 1'b1;
        cur_req = "R1";
        rd(0); rd(1); rd(2); rd(3); rd(4); rd(15);

        // R12: priority nibbles, bit 3 not stored
        cur_req = "R12";
        wr(3, 16'h9ABC); rd(3);
        wr(4, 16'h5670); rd(4);
        wr(0, 1); rd(0); wr(0, 0); rd(0);

        // R2: edge sets, write-1 clears, write-0 ignored
        cur_req = "R2";
        pulse(8'h05); rd(1);
        wr(1, 16'h0000); rd(1);
        wr(1, 16'h0001); rd(1);
        src_in = 8'h08; cyc(3); rd(1);
        src_in = '0; step();

        // R4: enable clear or priority 0 blocks the request
        cur_req = "R4";
        cyc(3);
        wr(2, 16'h0010); pulse(8'h10); cyc(3); rd(1);
        wr(2, 16'h0000); wr(1, 16'hFFFF); rd(1);

        // R5: priority and index order
        cur_req = "R5";
        wr(2, 16'h00FF);
        pulse(8'h06); cyc(2);
        wr(4, 16'h5330); pulse(8'h60); cyc(2);
        wr(1, 16'h0002); cyc(2);
        pulse(8'h80); cyc(2);
        wr(1, 16'hFFFF); cyc(2);

        // R6: strict compare with CPU level, trap bit blocks
        cur_req = "R6";
        cpu_ipl = 3'd4; pulse(8'h01); cyc(2);
        cpu_ipl = 3'd3; cyc(2);
        cpu_trap = 1'b1; cpu_ipl = 3'd0; cyc(3);
        cpu_trap = 1'b0; cyc(2);

        // R7: registered request timing on a fresh edge
        cur_req = "R7";
        wr(1, 16'hFFFF); step();
        src_in = 8'h20; step(); step(); src_in = '0; cyc(2);

        // R8: acknowledge enters service; stray acknowledge ignored
        cur_req = "R8";
        irq_ack = 1'b1; cpu_ipl = 3'd3; step(); irq_ack = 1'b0; cyc(2);
        irq_ret = 1'b1; step(); irq_ret = 1'b0; cyc(2);
        irq_ack = 1'b1; step(); irq_ack = 1'b0; cyc(2);
        cpu_ipl = 3'd0; cyc(2);

        // R9: status frozen during service with nesting off
        cur_req = "R9";
        wr(0, 1);
        rd(15);
        irq_ack = 1'b1; cpu_ipl = 3'd3; step(); irq_ack = 1'b0;
        pulse(8'h80); rd(15); cyc(3);
        irq_ret = 1'b1; step(); irq_ret = 1'b0; rd(15); cyc(2);

        // R10: nesting off blocks everything during service
        cur_req = "R10";
        irq_ack = 1'b1; cpu_ipl = 3'd5; step(); irq_ack = 1'b0;
        cpu_ipl = 3'd0; cyc(4);
        irq_ret = 1'b1; step(); irq_ret = 1'b0; cyc(2);

        // R11: nested service with depth counting
        cur_req = "R11";
        wr(0, 0);
        irq_ack = 1'b1; cpu_ipl = 3'd5; step(); irq_ack = 1'b0;
        wr(1, 16'h0080); cyc(2);
        cpu_ipl = 3'd2; cyc(2);
        irq_ack = 1'b1; cpu_ipl = 3'd3; step(); irq_ack = 1'b0; cyc(2);
        irq_ret = 1'b1; step(); irq_ret = 1'b0; cyc(2); rd(15);
        irq_ret = 1'b1; step(); irq_ret = 1'b0; cyc(2); rd(15);

        // R3: edge and clear in the same cycle
        cur_req = "R3";
        wr(1, 16'hFFFF); rd(1);
        bus_we = 1'b1; bus_addr = 4'd1; bus_wdata = 16'h0001; src_in = 8'h01;
        step();
        bus_we = 1'b0; src_in = '0;
        rd(1); cyc(2);

        finish_run();
    end

endmodule